// File: doc/BRIEF.md
# Cascadable FIFO with half-full flag

A first-in first-out buffer of 9-bit words with a depth set by parameter. A producer stores a word by pulsing the active-low write strobe, and a consumer takes a word by pulsing the active-low read strobe. One system clock samples both strobes, and the block detects their edges internally. A write lands on its start (falling) edge. A read presents the oldest word while its strobe is low, and the read pointer moves on the end (rising) edge. The block reports occupancy through active-low full and empty flags.

The expansion output has two uses, and the level on the expansion input during reset picks between them. If that input is held low through reset, the device works alone and the output is an active-low half-full flag. If it is high through reset, the device is one link in a ring of devices that together form one deeper buffer. In that case the output sends a one-cycle low pulse to the next device each time this device writes its last location and each time it finishes reading its last location. The pulses pass a write token and a read token around the ring, so exactly one device accepts writes and exactly one device answers reads at any moment. Strobes have no back-pressure handshake. A write made while full, or while the device lacks the write token, is dropped. A read made while empty, or without the read token, moves nothing. The producer and consumer watch the flags and pace themselves.

Top module: `casc_fifo`

## Requirements
- R1: While `rst_n` is low and for the cycles after it rises, `empty_n` is 0, `full_n` is 1 and, in single mode, `exp_out` is 1. Both pointers start at location 0.
- R2: Words come out in the order they were written. Each flag updates at the clock edge that samples the strobe edge, so it is settled one cycle after that edge.
- R3: With no reads since reset, `full_n` goes to 0 after exactly DEPTH accepted writes. A write started while `full_n` is 0 is dropped and leaves the contents unchanged.
- R4: While occupancy is zero, `empty_n` is 0. A read started then moves no pointer, so the next word written is the next word read.
- R5: In single mode, `exp_out` (half-full, active low) goes to 0 on the write start that raises occupancy above DEPTH/2.
- R6: In single mode, `exp_out` returns to 1 on the read end that brings occupancy to DEPTH/2 or less.
- R7: `q_oe` is 0 whenever `rd_n` is 1. `q` is driven only while `q_oe` is 1 and is high impedance otherwise.
- R8: The level of `exp_in` in the last reset cycle selects the mode: 0 gives single mode, with `exp_out` as the half-full flag, and 1 gives chain mode.
- R9: In chain mode, `exp_out` is normally 1. It goes to 0 for exactly one clock after a write to the last location is accepted, and again after a read of the last location ends. Back-to-back events give separate pulses.
- R10: In chain mode, a device with `chain_head` = 1 holds both tokens after reset, and any other device holds neither. Writes are accepted only while the device holds the write token, and reads only while it holds the read token. A device gives up a token when it sends the matching pulse. Falling edges on `exp_in` grant the write token and then the read token, in alternation.
- R11: Both pointers wrap from location DEPTH-1 to 0, and the FIFO order holds across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous reset, active low; strobes must be high around its release |
| wr_n | input | 1 | Write strobe, active low; the word is stored on the falling edge |
| rd_n | input | 1 | Read strobe, active low; the pointer advances on the rising edge |
| din | input | 9 | Write data, sampled with the write start edge |
| q | output | 9 | Read data; high impedance when `q_oe` is 0 |
| q_oe | output | 1 | High while this device drives `q` |
| full_n | output | 1 | Low when occupancy equals DEPTH |
| empty_n | output | 1 | Low when occupancy is zero |
| exp_in | input | 1 | Tie low for single mode; in a ring, connect to the previous device's `exp_out` |
| exp_out | output | 1 | Half-full flag in single mode; token pulse to the next device in chain mode |
| chain_head | input | 1 | High on the device that starts with both tokens in chain mode |

## Verification
The hardest state to reach is token hand-off around a ring. A device must fill completely before its write token moves on, and it must drain completely before its read token follows. The stimulus therefore builds a two-device ring of small depth and writes twice the single depth, so the write token goes to the second device and comes back to the first. It then reads everything back, so the read token makes the same round. This checks that exactly one device drives data on each read, and it counts the pulses each device sends. A single device of depth 16 gets a sweep over every fill level from empty to past full, draining after each one. A separate partial fill, drain and refill forces both pointers across the wrap.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;
  localparam int WORD_W = 9;

  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } fifo_mode_e;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/casc_fifo_edge.sv
module casc_fifo_edge
  import casc_fifo_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic ev
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign ev = prev_q & ~lvl;
    end else begin : g_rise
      assign ev = ~prev_q & lvl;
    end
  endgenerate
endmodule

// File: rtl/casc_fifo_store.sv
module casc_fifo_store #(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/casc_fifo_token.sv
module casc_fifo_token (
  input  logic clk,
  input  logic rst_n,
  input  logic chain,
  input  logic head,
  input  logic in_ev,
  input  logic wr_last,
  input  logic rd_last,
  output logic wtok,
  output logic rtok,
  output logic pulse_n
);
  logic       want_w;
  logic [1:0] pend;
  logic       wr_g, rd_g, in_g;
  logic [2:0] tot;

  assign wr_g = chain & wr_last;
  assign rd_g = chain & rd_last;
  assign in_g = chain & in_ev;
  assign tot  = {1'b0, pend} + {2'b0, wr_g} + {2'b0, rd_g};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wtok    <= head;
      rtok    <= head;
      want_w  <= 1'b1;
      pulse_n <= 1'b1;
      pend    <= 2'd0;
    end else begin
      if (wr_g) wtok <= 1'b0;
      if (rd_g) rtok <= 1'b0;
      if (in_g) begin
        if (want_w) wtok <= 1'b1;
        else        rtok <= 1'b1;
        want_w <= ~want_w;
      end
      if (pulse_n && tot != 3'd0) begin
        pulse_n <= 1'b0;
        pend    <= 2'(tot - 3'd1);
      end else begin
        pulse_n <= 1'b1;
        pend    <= tot[1:0];
      end
    end
  end

  // R9: every token pulse is a single cycle low
  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_n |=> pulse_n);
endmodule

// File: rtl/casc_fifo.sv
module casc_fifo
  import casc_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic          q_oe,
  output logic          full_n,
  output logic          empty_n,
  input  logic          exp_in,
  output logic          exp_out,
  input  logic          chain_head
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  fifo_mode_e mode_q;
  logic wr_start, rd_start, rd_end, xin_fall;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic rd_pend;
  logic wtok, rtok, pulse_n;
  logic wr_allow, rd_allow, wr_acc, rd_done;
  logic [DW-1:0] rdata;

  // mode is latched from exp_in while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= exp_in ? MODE_CHAIN : MODE_SOLO;
  end

  casc_fifo_edge #(.KIND(EDGE_FALL)) u_wr_fall (.clk(clk), .rst_n(rst_n), .lvl(wr_n),   .ev(wr_start));
  casc_fifo_edge #(.KIND(EDGE_FALL)) u_rd_fall (.clk(clk), .rst_n(rst_n), .lvl(rd_n),   .ev(rd_start));
  casc_fifo_edge #(.KIND(EDGE_RISE)) u_rd_rise (.clk(clk), .rst_n(rst_n), .lvl(rd_n),   .ev(rd_end));
  casc_fifo_edge #(.KIND(EDGE_FALL)) u_xi_fall (.clk(clk), .rst_n(rst_n), .lvl(exp_in), .ev(xin_fall));

  assign wr_allow = (mode_q == MODE_SOLO) || wtok;
  assign rd_allow = (mode_q == MODE_SOLO) || rtok;
  assign wr_acc   = wr_start && (count != CW'(DEPTH)) && wr_allow;
  assign rd_done  = rd_end && rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (rd_start)     rd_pend <= (count != '0) && rd_allow;
      else if (rd_end)  rd_pend <= 1'b0;
      if (wr_acc)  wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (rd_done) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      count <= count + CW'(wr_acc) - CW'(rd_done);
    end
  end

  casc_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(din),
    .raddr(rptr), .rdata(rdata)
  );

  casc_fifo_token u_token (
    .clk(clk), .rst_n(rst_n), .chain(mode_q == MODE_CHAIN), .head(chain_head),
    .in_ev(xin_fall), .wr_last(wr_acc && wptr == LAST),
    .rd_last(rd_done && rptr == LAST),
    .wtok(wtok), .rtok(rtok), .pulse_n(pulse_n)
  );

  assign full_n  = (count != CW'(DEPTH));
  assign empty_n = (count != '0);
  assign exp_out = (mode_q == MODE_SOLO) ? !(count > CW'(HALF)) : pulse_n;
  assign q_oe    = !rd_n && rd_allow;
  assign q       = q_oe ? rdata : {DW{1'bz}};

  // pointer distance must always match the occupancy count
  logic [CW:0] gap;
  assign gap = (CW+1)'(wptr) + ((wptr < rptr) ? (CW+1)'(DEPTH) : '0) - (CW+1)'(rptr);

  // R3: occupancy never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2: pointers and count stay consistent (FIFO ordering, R11 wrap)
  p_ptr_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap == ((count == CW'(DEPTH)) ? '0 : (CW+1)'(count)));
  // R4: an empty device stays empty unless a write is accepted
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !wr_acc) |=> (count == '0));
endmodule

// File: tb/casc_fifo_test.sv
`timescale 1ns/1ps
module casc_fifo_test;
  localparam int SD = 16;
  localparam int CD = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] u_q;
  logic u_oe, u_full_n, u_empty_n, u_xo;

  logic cwr_n = 1'b1, crd_n = 1'b1;
  logic [8:0] cdin = '0;
  logic [8:0] a_q, b_q;
  logic a_oe, b_oe, a_full_n, b_full_n, a_empty_n, b_empty_n, a_xo, b_xo;

  int total = 0;
  int bad = 0;
  int a_pc = 0;
  int b_pc = 0;

  casc_fifo #(.DEPTH(SD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .q(u_q), .q_oe(u_oe), .full_n(u_full_n), .empty_n(u_empty_n),
    .exp_in(1'b0), .exp_out(u_xo), .chain_head(1'b1));

  casc_fifo #(.DEPTH(CD)) dev_a (
    .clk(clk), .rst_n(rst_n), .wr_n(cwr_n), .rd_n(crd_n), .din(cdin),
    .q(a_q), .q_oe(a_oe), .full_n(a_full_n), .empty_n(a_empty_n),
    .exp_in(b_xo), .exp_out(a_xo), .chain_head(1'b1));

  casc_fifo #(.DEPTH(CD)) dev_b (
    .clk(clk), .rst_n(rst_n), .wr_n(cwr_n), .rd_n(crd_n), .din(cdin),
    .q(b_q), .q_oe(b_oe), .full_n(b_full_n), .empty_n(b_empty_n),
    .exp_in(a_xo), .exp_out(b_xo), .chain_head(1'b0));

  always @(negedge clk) begin
    if (rst_n) begin
      if (!a_xo) a_pc++;
      if (!b_xo) b_pc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; cwr_n = 1'b1; crd_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    a_pc = 0; b_pc = 0;
  endtask

  task automatic do_write(input bit ch, input logic [8:0] d);
    @(negedge clk);
    if (ch) begin cdin = d; cwr_n = 1'b0; end
    else    begin din = d;  wr_n = 1'b0;  end
    @(negedge clk);
    if (ch) cwr_n = 1'b1; else wr_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input bit ch, output logic [8:0] got, output int drivers);
    @(negedge clk);
    if (ch) crd_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    if (ch) begin
      drivers = int'(a_oe) + int'(b_oe);
      got = a_oe ? a_q : b_q;
      crd_n = 1'b1;
    end else begin
      drivers = int'(u_oe);
      got = u_q;
      rd_n = 1'b1;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [8:0] pat(input int n, input int i);
    return 9'((n * 37 + i * 11) % 512);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [8:0] got;
    int drv;
    int acc;

    // R1: flags during reset
    repeat (3) @(negedge clk);
    chk("R1 empty_n in reset", int'(u_empty_n), 0);
    chk("R1 full_n in reset", int'(u_full_n), 1);

    // single-device sweep over every fill level, past full
    for (int n = 0; n <= SD + 2; n++) begin
      do_reset();
      chk("R1 empty_n after reset", int'(u_empty_n), 0);
      chk("R1 full_n after reset", int'(u_full_n), 1);
      chk("R8 single hf idle", int'(u_xo), 1);
      chk("R7 oe low while rd_n high", int'(u_oe), 0);
      for (int i = 0; i < n; i++) begin
        do_write(1'b0, pat(n, i));
        acc = (i + 1 > SD) ? SD : i + 1;
        chk("R5 hf after write", int'(u_xo), (acc > SD / 2) ? 0 : 1);
        chk("R3 full_n after write", int'(u_full_n), (acc == SD) ? 0 : 1);
      end
      acc = (n > SD) ? SD : n;
      chk("R4 empty_n after fill", int'(u_empty_n), (acc == 0) ? 0 : 1);
      for (int k = 0; k < acc; k++) begin
        do_read(1'b0, got, drv);
        chk("R7 oe while reading", drv, 1);
        chk("R2 read order", int'(got), int'(pat(n, k)));
        chk("R6 hf after read", int'(u_xo), (acc - k - 1 > SD / 2) ? 0 : 1);
      end
      chk("R4 empty_n drained", int'(u_empty_n), 0);
      chk("R3 full_n drained", int'(u_full_n), 1);
      // R4: read while empty moves nothing
      do_read(1'b0, got, drv);
      chk("R4 empty_n after empty read", int'(u_empty_n), 0);
      do_write(1'b0, 9'h1a5);
      do_read(1'b0, got, drv);
      chk("R4 word after empty read", int'(got), 9'h1a5);
    end

    // R11: wrap of both pointers
    do_reset();
    for (int i = 0; i < 10; i++) do_write(1'b0, pat(100, i));
    for (int i = 0; i < 10; i++) begin
      do_read(1'b0, got, drv);
      chk("R11 pre-wrap order", int'(got), int'(pat(100, i)));
    end
    for (int i = 0; i < SD; i++) do_write(1'b0, pat(200, i));
    chk("R11 full after wrap fill", int'(u_full_n), 0);
    do_write(1'b0, 9'h0ff);
    for (int i = 0; i < SD; i++) begin
      do_read(1'b0, got, drv);
      chk("R11 wrapped order", int'(got), int'(pat(200, i)));
    end
    chk("R11 empty after wrap", int'(u_empty_n), 0);

    // chain of two devices
    do_reset();
    chk("R8 chain exp_out idle a", int'(a_xo), 1);
    chk("R8 chain exp_out idle b", int'(b_xo), 1);
    chk("R10 b holds no token", int'(b_empty_n), 0);
    for (int i = 0; i < CD; i++) do_write(1'b1, pat(300, i));
    chk("R10 a full", int'(a_full_n), 0);
    chk("R10 b empty before token", int'(b_empty_n), 0);
    chk("R9 a pulses after fill", a_pc, 1);
    for (int i = CD; i < 2 * CD; i++) do_write(1'b1, pat(300, i));
    chk("R10 b full", int'(b_full_n), 0);
    chk("R9 b pulses after fill", b_pc, 1);
    do_write(1'b1, 9'h155);
    chk("R3 chain extra write dropped a", int'(a_full_n), 0);
    for (int i = 0; i < 2 * CD; i++) begin
      do_read(1'b1, got, drv);
      chk("R10 single driver", drv, 1);
      chk("R2 chain order", int'(got), int'(pat(300, i)));
    end
    chk("R9 a pulses total", a_pc, 2);
    chk("R9 b pulses total", b_pc, 2);
    chk("R4 a drained", int'(a_empty_n), 0);
    chk("R4 b drained", int'(b_empty_n), 0);
    do_write(1'b1, 9'h0a1);
    do_write(1'b1, 9'h0b2);
    chk("R10 write token returned to a", int'(a_empty_n), 1);
    chk("R10 b untouched", int'(b_empty_n), 0);
    do_read(1'b1, got, drv);
    chk("R10 read token returned to a", int'(got), 9'h0a1);
    do_read(1'b1, got, drv);
    chk("R10 second word", int'(got), 9'h0b2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule